// File: doc/BRIEF.md
# Time-Shared Multiply-Accumulate FIR Filter

This block computes a finite impulse response filter with a single multiplier and a single accumulator. The same multiplier and accumulator handle every tap in turn. Each accepted input sample is written into a circular sample store that holds as many entries as there are taps. A sequencer then steps through every tap. For each tap it pairs one stored sample with its fixed coefficient, and the products are summed. The finished sum is placed in an output register at full precision, and a one-cycle valid strobe marks it.

The design gives up output rate to save area. A new sample can be taken once every TAPS clock cycles, so the sample rate is the clock rate divided by the tap count. Samples come in through a valid/ready handshake. The result has only a valid strobe. The coefficients are fixed when the block is elaborated and are computed from two parameters.

Top module: `mac_fir`

## Requirements
- R1: Each result equals y(n) = sum for i from 0 to TAPS-1 of x(n-i)·h(i). Samples and coefficients are signed two's complement, x(n) is the newest accepted sample, and positions older than the first sample accepted since reset count as zero.
- R2: Coefficient h(i) is the lowest COEF_W bits of (i·COEF_STEP + COEF_BASE), read as a signed number. The defaults are TAPS=92, SAMPLE_W=8, COEF_W=12, COEF_STEP=1237 and COEF_BASE=301.
- R3: out_result has SAMPLE_W+COEF_W+ceil(log2(TAPS)) bits (27 by default). It holds the exact sum without wrapping, even when every stored sample is at its most negative or most positive value.
- R4: in_ready is high while no result is being computed. A sample is taken on a rising clock edge where in_valid and in_ready are both high.
- R5: After a sample is taken, in_ready is low until the cycle in which the last tap is issued. With in_valid held high, consecutive samples are therefore taken exactly TAPS cycles apart.
- R6: Every accepted sample produces exactly one out_valid pulse, one cycle wide, on the TAPS+2+PIPE_MULT-th rising edge after the accepting edge (95 edges by default).
- R7: out_result changes only on the edge that raises out_valid, and holds its value at all other times.
- R8: in_sample has no effect on any later result while in_valid is low or in_ready is low.
- R9: After reset, out_valid is low, out_result is zero, in_ready is high and every entry of the sample store reads as zero.
- R10: The coefficient index counts up from 0 to TAPS-1. The sample index counts down from the newest entry and wraps modulo TAPS. A sample therefore stops contributing after TAPS newer samples, and an isolated unit impulse produces h(0), h(1), …, h(TAPS-1) followed by zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample is offered |
| in_ready | output | 1 | Block can take a sample this cycle |
| in_sample | input | SAMPLE_W | Signed input sample |
| out_valid | output | 1 | One-cycle strobe marking a new result |
| out_result | output | SAMPLE_W+COEF_W+clog2(TAPS) | Signed full-precision filter output |

## Verification
The bound checker watches the sequencer on every cycle. It checks that the coefficient index steps up by one and the sample index steps down with wrap between issued taps, that in_ready drops after a sample is taken, and that out_valid is a single-cycle pulse owed to an earlier accepted sample. It also checks that the result register stays stable between pulses and that no more than two results are ever in flight. The arithmetic itself can only be shown by the bench scenarios, because it needs a reference model: the unit impulse that reveals coefficient order and ring wrap, full-scale runs that exercise accumulator growth, random sequences with gaps and garbage on the idle data lines, and back-to-back streaming that measures the accept spacing and the output latency.

// File: rtl/mac_fir_pkg.sv
package mac_fir_pkg;

   // Sequencer state
   typedef enum logic {
      SEQ_IDLE = 1'b0,
      SEQ_RUN  = 1'b1
   } seq_state_t;

   // Control tag that travels down the pipeline beside each tap's data
   typedef struct packed {
      logic vld;    // a tap is present in this stage
      logic first;  // first tap of a result: load instead of add
      logic last;   // last tap of a result: capture after this one
   } tap_tag_t;

   localparam tap_tag_t TAG_NONE = '{vld: 1'b0, first: 1'b0, last: 1'b0};

endpackage

// File: rtl/mac_fir_seq.sv
module mac_fir_seq
   import mac_fir_pkg::*;
#(
   parameter int TAPS = 92,
   localparam int AW  = $clog2(TAPS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   output logic          in_ready,
   output logic          wr_en,
   output logic [AW-1:0] wr_addr,
   output tap_tag_t      issue_tag,
   output logic [AW-1:0] coef_addr,
   output logic [AW-1:0] samp_addr
);

   localparam logic [AW-1:0] LAST_IDX = AW'(TAPS - 1);

   seq_state_t    state_q;
   logic [AW-1:0] tap_q;
   logic [AW-1:0] rd_ptr_q;
   logic [AW-1:0] newest_q;
   logic          last_tap;
   logic          accept;

   assign last_tap = (state_q == SEQ_RUN) && (tap_q == LAST_IDX);
   // The slot read on the last tap is the next one to be written, and the
   // ring reads before it writes, so a new sample may enter on that cycle.
   assign in_ready = (state_q == SEQ_IDLE) || last_tap;
   assign accept   = in_valid && in_ready;

   assign wr_en    = accept;
   assign wr_addr  = (newest_q == LAST_IDX) ? '0 : newest_q + AW'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= SEQ_IDLE;
         tap_q    <= '0;
         rd_ptr_q <= '0;
         newest_q <= LAST_IDX;
      end else if (accept) begin
         state_q  <= SEQ_RUN;
         tap_q    <= '0;
         rd_ptr_q <= wr_addr;
         newest_q <= wr_addr;
      end else if (last_tap) begin
         state_q  <= SEQ_IDLE;
      end else if (state_q == SEQ_RUN) begin
         tap_q    <= tap_q + AW'(1);
         rd_ptr_q <= (rd_ptr_q == '0) ? LAST_IDX : rd_ptr_q - AW'(1);
      end
   end

   always_comb begin
      issue_tag       = TAG_NONE;
      issue_tag.vld   = (state_q == SEQ_RUN);
      issue_tag.first = (state_q == SEQ_RUN) && (tap_q == '0);
      issue_tag.last  = last_tap;
   end

   assign coef_addr = tap_q;
   assign samp_addr = rd_ptr_q;

endmodule

// File: rtl/mac_fir_mem.sv
module mac_fir_mem
   import mac_fir_pkg::*;
#(
   parameter int TAPS      = 92,
   parameter int SAMPLE_W  = 8,
   parameter int COEF_W    = 12,
   parameter int COEF_STEP = 1237,
   parameter int COEF_BASE = 301,
   localparam int AW       = $clog2(TAPS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [AW-1:0]       wr_addr,
   input  logic [SAMPLE_W-1:0] wr_data,
   input  tap_tag_t            rd_tag,
   input  logic [AW-1:0]       samp_addr,
   input  logic [AW-1:0]       coef_addr,
   output logic [SAMPLE_W-1:0] samp_q,
   output logic [COEF_W-1:0]   coef_q,
   output tap_tag_t            tag_q
);

   logic [SAMPLE_W-1:0] ring_q [TAPS];
   logic [COEF_W-1:0]   rom    [TAPS];

   // Fixed coefficient table, one constant per entry
   for (genvar g = 0; g < TAPS; g++) begin : g_rom
      assign rom[g] = COEF_W'(g * COEF_STEP + COEF_BASE);
   end

   // Circular sample store, cleared by reset so history starts at zero
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < TAPS; i++) ring_q[i] <= '0;
      end else if (wr_en) begin
         ring_q[wr_addr] <= wr_data;
      end
   end

   // Registered read port; it sees the value held before a same-cycle write
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         samp_q <= '0;
         coef_q <= '0;
         tag_q  <= TAG_NONE;
      end else begin
         tag_q <= rd_tag;
         if (rd_tag.vld) begin
            samp_q <= ring_q[samp_addr];
            coef_q <= rom[coef_addr];
         end
      end
   end

endmodule

// File: rtl/mac_fir_dp.sv
module mac_fir_dp
   import mac_fir_pkg::*;
#(
   parameter int SAMPLE_W  = 8,
   parameter int COEF_W    = 12,
   parameter int ACC_W     = 27,
   parameter bit PIPE_MULT = 1'b1,
   localparam int PROD_W   = SAMPLE_W + COEF_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [SAMPLE_W-1:0] samp,
   input  logic [COEF_W-1:0]   coef,
   input  tap_tag_t            tag,
   output logic                res_valid,
   output logic [ACC_W-1:0]    res
);

   logic signed [PROD_W-1:0] prod_c;
   logic signed [PROD_W-1:0] prod_s;
   tap_tag_t                 tag_s;
   logic        [ACC_W-1:0]  prod_ext;
   logic        [ACC_W-1:0]  acc_q;
   logic                     done_q;

   assign prod_c = $signed(samp) * $signed(coef);

   if (PIPE_MULT) begin : g_mult_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            prod_s <= '0;
            tag_s  <= TAG_NONE;
         end else begin
            prod_s <= prod_c;
            tag_s  <= tag;
         end
      end
   end else begin : g_mult_comb
      assign prod_s = prod_c;
      assign tag_s  = tag;
   end

   assign prod_ext = {{(ACC_W - PROD_W){prod_s[PROD_W-1]}}, prod_s};

   // The first tap loads the product, so no clear cycle is spent
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q  <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= tag_s.vld && tag_s.last;
         if (tag_s.vld) acc_q <= tag_s.first ? prod_ext : acc_q + prod_ext;
      end
   end

   // Result capture register
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res       <= '0;
         res_valid <= 1'b0;
      end else begin
         res_valid <= done_q;
         if (done_q) res <= acc_q;
      end
   end

endmodule

// File: rtl/mac_fir.sv
module mac_fir
   import mac_fir_pkg::*;
#(
   parameter int TAPS      = 92,
   parameter int SAMPLE_W  = 8,
   parameter int COEF_W    = 12,
   parameter int COEF_STEP = 1237,
   parameter int COEF_BASE = 301,
   parameter bit PIPE_MULT = 1'b1
) (
   input  logic                                          clk,
   input  logic                                          rst_n,
   input  logic                                          in_valid,
   output logic                                          in_ready,
   input  logic [SAMPLE_W-1:0]                           in_sample,
   output logic                                          out_valid,
   output logic [SAMPLE_W+COEF_W+$clog2(TAPS)-1:0]       out_result
);

   localparam int AW    = $clog2(TAPS);
   localparam int ACC_W = SAMPLE_W + COEF_W + AW;

   if (TAPS < 2) begin : g_bad_taps
      $error("mac_fir: TAPS must be at least 2");
   end
   if (SAMPLE_W < 2 || COEF_W < 2) begin : g_bad_width
      $error("mac_fir: sample and coefficient widths must be at least 2");
   end

   logic          wr_en;
   logic [AW-1:0] wr_addr;
   tap_tag_t      issue_tag;
   tap_tag_t      rd_tag;
   logic [AW-1:0] coef_addr;
   logic [AW-1:0] samp_addr;
   logic          issue_vld;
   logic [SAMPLE_W-1:0] samp_q;
   logic [COEF_W-1:0]   coef_q;

   assign issue_vld = issue_tag.vld;

   mac_fir_seq #(.TAPS(TAPS)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_ready  (in_ready),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .issue_tag (issue_tag),
      .coef_addr (coef_addr),
      .samp_addr (samp_addr)
   );

   mac_fir_mem #(
      .TAPS(TAPS), .SAMPLE_W(SAMPLE_W), .COEF_W(COEF_W),
      .COEF_STEP(COEF_STEP), .COEF_BASE(COEF_BASE)
   ) u_mem (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (in_sample),
      .rd_tag    (issue_tag),
      .samp_addr (samp_addr),
      .coef_addr (coef_addr),
      .samp_q    (samp_q),
      .coef_q    (coef_q),
      .tag_q     (rd_tag)
   );

   mac_fir_dp #(
      .SAMPLE_W(SAMPLE_W), .COEF_W(COEF_W), .ACC_W(ACC_W), .PIPE_MULT(PIPE_MULT)
   ) u_dp (
      .clk       (clk),
      .rst_n     (rst_n),
      .samp      (samp_q),
      .coef      (coef_q),
      .tag       (rd_tag),
      .res_valid (out_valid),
      .res       (out_result)
   );

endmodule

// File: rtl/mac_fir_chk.sv
module mac_fir_chk #(
   parameter int TAPS  = 92,
   parameter int AW    = 7,
   parameter int ACC_W = 27
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic             in_ready,
   input logic             out_valid,
   input logic [ACC_W-1:0] out_result,
   input logic             issue_vld,
   input logic [AW-1:0]    coef_addr,
   input logic [AW-1:0]    samp_addr
);

   localparam logic [AW-1:0] LAST_IDX = AW'(TAPS - 1);

   logic [1:0] pend_q;
   logic       acc_ev;
   assign acc_ev = in_valid && in_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= '0;
      else if (acc_ev && !out_valid) pend_q <= pend_q + 2'd1;
      else if (!acc_ev && out_valid) pend_q <= pend_q - 2'd1;
   end

   p_coef_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_vld && coef_addr != LAST_IDX) |=>
         (issue_vld && coef_addr == $past(coef_addr) + AW'(1)));

   p_samp_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_vld && coef_addr != LAST_IDX) |=>
         (samp_addr == (($past(samp_addr) == '0) ? LAST_IDX : $past(samp_addr) - AW'(1))));

   p_busy_after_take_r5: assert property (@(posedge clk) disable iff (!rst_n)
      acc_ev |=> !in_ready);

   p_idle_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !issue_vld |-> in_ready);

   p_single_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid);

   p_pulse_owed_r6: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> pend_q != 2'd0);

   p_inflight_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q <= 2'd2);

   p_result_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> $stable(out_result));

endmodule

bind mac_fir mac_fir_chk #(.TAPS(TAPS), .AW(AW), .ACC_W(ACC_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .in_ready   (in_ready),
   .out_valid  (out_valid),
   .out_result (out_result),
   .issue_vld  (issue_vld),
   .coef_addr  (coef_addr),
   .samp_addr  (samp_addr)
);

// File: tb/mac_fir_tb.sv
`timescale 1ns/1ps
module mac_fir_tb;

   localparam int TAPS      = 92;
   localparam int SAMPLE_W  = 8;
   localparam int COEF_W    = 12;
   localparam int COEF_STEP = 1237;
   localparam int COEF_BASE = 301;
   localparam int ACC_W     = SAMPLE_W + COEF_W + $clog2(TAPS);
   localparam int LAT       = TAPS + 3;   // R6 with the multiplier register

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0;
   logic in_ready;
   logic [SAMPLE_W-1:0] in_sample = '0;
   logic out_valid;
   logic [ACC_W-1:0] out_result;

   always #10 clk = ~clk;

   mac_fir #(
      .TAPS(TAPS), .SAMPLE_W(SAMPLE_W), .COEF_W(COEF_W),
      .COEF_STEP(COEF_STEP), .COEF_BASE(COEF_BASE), .PIPE_MULT(1'b1)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_sample(in_sample), .out_valid(out_valid), .out_result(out_result)
   );

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   bit finished = 1'b0;

   int hist [TAPS];
   int newest = TAPS - 1;
   int exp_q [$];
   int due_q [$];
   string req_q [$];
   string cur_req = "R1";
   int last_res = 0;
   int prev_take = -1;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   // R2 coefficient rule, computed independently
   function automatic int coef_h(input int i);
      int v;
      v = (i * COEF_STEP + COEF_BASE) & ((1 << COEF_W) - 1);
      if (v >= (1 << (COEF_W - 1))) v -= (1 << COEF_W);
      return v;
   endfunction

   // R1 reference sum over the history
   function automatic int ref_y();
      int s = 0;
      for (int i = 0; i < TAPS; i++) s += hist[(newest - i + TAPS) % TAPS] * coef_h(i);
      return s;
   endfunction

   function automatic int sext(input logic [SAMPLE_W-1:0] x);
      return int'($signed(x));
   endfunction

   // Offer one sample; enter and leave at a falling edge
   task automatic send(input int x, input int gap, input bit stream);
      bit ok;
      int t;
      in_valid  = 1'b1;
      in_sample = SAMPLE_W'(x);
      ok = 1'b0;
      while (!ok) begin
         ok = in_ready;
         t  = cyc;
         @(negedge clk);
      end
      newest = (newest + 1) % TAPS;
      hist[newest] = sext(SAMPLE_W'(x));
      exp_q.push_back(ref_y());
      due_q.push_back(t + 1 + LAT);
      req_q.push_back(cur_req);
      if (stream && prev_take >= 0)
         chk((t - prev_take) == TAPS, "R5 accept spacing", t - prev_take, TAPS);
      prev_take = t;
      in_valid = 1'b0;
      if (!stream) chk(in_ready == 1'b0, "R5 busy after take", int'(in_ready), 0);
      for (int g = 0; g < gap; g++) begin
         in_sample = SAMPLE_W'($urandom);   // R8 garbage while not offered
         @(negedge clk);
      end
   endtask

   // Output monitor
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         if (out_valid) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R6 unexpected pulse", 1, 0);
            end else begin
               int e, d;
               string r;
               e = exp_q.pop_front();
               d = due_q.pop_front();
               r = req_q.pop_front();
               chk(int'($signed(out_result)) == e, r, int'($signed(out_result)), e);
               chk(cyc == d, "R6 latency", cyc, d);
            end
            last_res = int'($signed(out_result));
         end else begin
            chk(int'($signed(out_result)) == last_res, "R7 hold",
                int'($signed(out_result)), last_res);
         end
      end
   end

   task automatic drain();
      for (int i = 0; i < 4 * LAT && exp_q.size() != 0; i++) @(negedge clk);
      repeat (3) @(negedge clk);
      chk(exp_q.size() == 0, "R6 missing pulse", exp_q.size(), 0);
   endtask

   task automatic summary();
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
      end
   end

   initial begin
      int seed;
      seed = $urandom(32'd4711);
      for (int i = 0; i < TAPS; i++) hist[i] = 0;
      repeat (3) @(negedge clk);
      // R9 reset state
      chk(in_ready == 1'b1, "R9 ready", int'(in_ready), 1);
      chk(out_valid == 1'b0, "R9 valid", int'(out_valid), 0);
      chk(out_result == '0, "R9 result", int'(out_result), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(in_ready == 1'b1, "R4 idle ready", int'(in_ready), 1);

      // R10 and R9: unit impulse into a cleared store, then zeros past the ring
      cur_req = "R10 impulse";
      send(1, 2, 1'b0);
      for (int i = 0; i < TAPS + 2; i++) send(0, 0, 1'b0);
      drain();

      // R3 full-scale growth, both extremes
      cur_req = "R3 negative full scale";
      for (int i = 0; i < TAPS + 1; i++) send(-(1 << (SAMPLE_W - 1)), 0, 1'b0);
      cur_req = "R3 positive full scale";
      for (int i = 0; i < TAPS + 1; i++) send((1 << (SAMPLE_W - 1)) - 1, 0, 1'b0);
      drain();

      // R1 and R8 random samples, random idle gaps with garbage data
      cur_req = "R1 random";
      for (int i = 0; i < 60; i++) send(int'($urandom), int'($urandom_range(0, 7)), 1'b0);
      drain();

      // R5 back-to-back streaming with in_valid held high
      cur_req = "R1 streaming";
      prev_take = -1;
      for (int i = 0; i < 12; i++) send(int'($urandom), 0, 1'b1);
      drain();

      // R8 long idle with garbage, then a single sample
      cur_req = "R8 after idle garbage";
      for (int i = 0; i < 20; i++) begin
         in_sample = SAMPLE_W'($urandom);
         @(negedge clk);
      end
      send(5, 2, 1'b0);
      drain();
      summary();
   end

endmodule